// File: doc/BRIEF.md
# Regex Instruction Sequencer

This block steps through a compiled program that matches several regular-expression patterns at once. An external comparator checks the operand of the current instruction against the text. The sequencer takes back the result, one hit or miss per instruction, and decides where the program goes next. It moves the program counter forward, keeps it on a repetition instruction, jumps to an alternative pattern, or sends the program back to instruction 0. It also tells the text side how much data was consumed and whether a restart has to rewind the text pointer.

Each instruction has a control word that is read from program memory at address `pc`. The operand characters go straight from memory to the comparator and do not pass through this block. The compare result arrives as a valid/ready stream. The sequencer takes a result on any cycle where `cmp_valid` and `cmp_ready` are both high. While `cmp_ready` is low, the comparator must hold its result steady. `cmp_ready` goes low only while the current instruction is MATCH, because MATCH needs no compare. All outputs are one-cycle event pulses with no back-pressure. The side that receives them must take each pulse in the cycle it appears.

Top module: `regex_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `pc` is 0 and `adv_valid`, `anchor_fwd`, `restart_valid`, `restart_rewind` and `match_valid` are all low.
- R2: The control word, from most significant bit down, is: opcode[13:11], rewind-free flag F[10], length field[9:8], offset/id[7:0]. The opcodes are CMP=0, ORX=1, STAR=2, PLUS=3, OPT=4, MATCH=5; the codes 6 and 7 behave as CMP. `cmp_ready` is low exactly when the current opcode is MATCH. A result is taken only when `cmp_valid` and `cmp_ready` are both high.
- R3: On a CMP hit, the sequencer moves to `pc`+1 and consumes data. On a CMP miss, it moves to `pc` 0 and raises `restart_valid`.
- R4: On an ORX hit, the sequencer moves to `pc`+1 and consumes data. On an ORX miss, it moves to `pc` plus the signed 8-bit offset, taken modulo the program size. An ORX miss consumes no data and raises no restart.
- R5: On a STAR hit, the sequencer stays at the same `pc` and consumes data. On a STAR miss, it moves to `pc`+1 and consumes nothing.
- R6: On a PLUS hit, the sequencer stays at the same `pc` and consumes data. A PLUS miss after at least one hit at that instruction moves to `pc`+1. A PLUS miss before any hit moves to `pc` 0 and raises a restart.
- R7: OPT always moves to `pc`+1. It consumes data only on a hit.
- R8: In any cycle whose current opcode is MATCH, the sequencer goes to `pc` 0. In the next cycle, `match_valid` is high for one cycle and `match_id` carries the low 8 bits of that control word.
- R9: `restart_rewind` is high with a restart only when the F bit of the most recent hit since the sequence began is 0. A sequence begins at reset, after a restart or after a MATCH, and at that point counts as F=1, so no rewind is needed.
- R10: `anchor_fwd` pulses together with `adv_valid` when the consumed instruction had F=1.
- R11: All events appear in the cycle after the edge that took the result, and each lasts one cycle. With no result taken and a non-MATCH opcode, `pc` holds and no event is raised.
- R12: While `adv_valid` is high, `adv_len` equals the length field of the instruction that consumed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 14 | Control word of the instruction at `pc` |
| pc | output | 6 | Current instruction address |
| cmp_valid | input | 1 | A compare result is offered |
| cmp_hit | input | 1 | The offered result is a match |
| cmp_ready | output | 1 | The sequencer takes the offered result |
| adv_valid | output | 1 | Text data was consumed |
| adv_len | output | 2 | Length field of the consuming instruction |
| anchor_fwd | output | 1 | The backtrack anchor may move forward |
| restart_valid | output | 1 | Restart request to the backtrack controller |
| restart_rewind | output | 1 | The restart must rewind the text pointer |
| match_valid | output | 1 | A pattern was recognised |
| match_id | output | 8 | Number of the recognised pattern |

## Verification
The hardest case to reach from the ports is a PLUS miss before its first hit that still produces a restart with rewind. For that, an instruction with F=0 has to hit just before the PLUS, and then the PLUS has to see a miss on its first compare. The bench's program places a STAR with F=0 ahead of a PLUS. Random hit/miss streams with several hit biases and idle gaps then steer the program into that path many times. A behavioural model checks every edge, including ORX jumps with both positive and negative offsets.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    OP_CMP   = 3'd0,
    OP_ORX   = 3'd1,
    OP_STAR  = 3'd2,
    OP_PLUS  = 3'd3,
    OP_OPT   = 3'd4,
    OP_MATCH = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } rxs_op_e;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_INC  = 2'd1,
    PC_JUMP = 2'd2,
    PC_ZERO = 2'd3
  } rxs_pcsel_e;

  typedef struct packed {
    rxs_pcsel_e sel;
    logic       adv;
    logic       restart;
    logic       match;
    logic       seen_set;
  } rxs_step_t;
endpackage

// File: rtl/rxs_decode.sv
module rxs_decode
  import rxs_pkg::*;
#(
  parameter int LEN_W = 2,
  parameter int OFF_W = 8,
  localparam int CTL_W = 3 + 1 + LEN_W + OFF_W
) (
  input  logic [CTL_W-1:0] ctl,
  output rxs_op_e          op,
  output logic             fbit,
  output logic [LEN_W-1:0] len,
  output logic [OFF_W-1:0] off
);
  assign op   = rxs_op_e'(ctl[CTL_W-1 -: 3]);
  assign fbit = ctl[LEN_W + OFF_W];
  assign len  = ctl[OFF_W +: LEN_W];
  assign off  = ctl[OFF_W-1:0];
endmodule

// File: rtl/rxs_step.sv
module rxs_step
  import rxs_pkg::*;
(
  input  rxs_op_e   op,
  input  logic      accept,
  input  logic      hit,
  input  logic      seen,
  output rxs_step_t step
);
  always_comb begin
    step = '{sel: PC_HOLD, adv: 1'b0, restart: 1'b0, match: 1'b0, seen_set: 1'b0};
    if (op == OP_MATCH) begin
      step.sel   = PC_ZERO;
      step.match = 1'b1;
    end else if (accept) begin
      unique case (op)
        OP_ORX: begin
          step.sel = hit ? PC_INC : PC_JUMP;
          step.adv = hit;
        end
        OP_STAR: begin
          step.sel = hit ? PC_HOLD : PC_INC;
          step.adv = hit;
        end
        OP_PLUS: begin
          if (hit) begin
            step.sel      = PC_HOLD;
            step.adv      = 1'b1;
            step.seen_set = 1'b1;
          end else if (seen) begin
            step.sel = PC_INC;
          end else begin
            step.sel     = PC_ZERO;
            step.restart = 1'b1;
          end
        end
        OP_OPT: begin
          step.sel = PC_INC;
          step.adv = hit;
        end
        default: begin
          step.sel     = hit ? PC_INC : PC_ZERO;
          step.adv     = hit;
          step.restart = !hit;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxs_pcgen.sv
module rxs_pcgen
  import rxs_pkg::*;
#(
  parameter int PC_W  = 6,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  rxs_pcsel_e       sel,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  pc_next
);
  localparam int EXT_W = (PC_W > OFF_W) ? PC_W : OFF_W;
  logic [EXT_W-1:0] off_ext;
  logic [EXT_W-1:0] jump_sum;

  assign off_ext  = EXT_W'($signed(off));
  assign jump_sum = EXT_W'(pc) + off_ext;

  always_comb begin
    unique case (sel)
      PC_INC:  pc_next = pc + PC_W'(1);
      PC_JUMP: pc_next = jump_sum[PC_W-1:0];
      PC_ZERO: pc_next = '0;
      default: pc_next = pc;
    endcase
  end
endmodule

// File: rtl/regex_seq.sv
module regex_seq
  import rxs_pkg::*;
#(
  parameter int PC_W  = 6,
  parameter int LEN_W = 2,
  parameter int OFF_W = 8,
  localparam int CTL_W = 3 + 1 + LEN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_word,
  output logic [PC_W-1:0]  pc,
  input  logic             cmp_valid,
  input  logic             cmp_hit,
  output logic             cmp_ready,
  output logic             adv_valid,
  output logic [LEN_W-1:0] adv_len,
  output logic             anchor_fwd,
  output logic             restart_valid,
  output logic             restart_rewind,
  output logic             match_valid,
  output logic [OFF_W-1:0] match_id
);
  rxs_op_e          op;
  logic             fbit;
  logic [LEN_W-1:0] len;
  logic [OFF_W-1:0] off;
  rxs_step_t        step;
  logic [PC_W-1:0]  pc_next;
  logic             accept;
  logic             seen_q;
  logic             nofail_q;

  rxs_decode #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_dec (
    .ctl(ctl_word), .op(op), .fbit(fbit), .len(len), .off(off)
  );

  assign cmp_ready = (op != OP_MATCH);
  assign accept    = cmp_valid && cmp_ready;

  rxs_step u_step (
    .op(op), .accept(accept), .hit(cmp_hit), .seen(seen_q), .step(step)
  );

  rxs_pcgen #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
    .pc(pc), .sel(step.sel), .off(off), .pc_next(pc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc             <= '0;
      seen_q         <= 1'b0;
      nofail_q       <= 1'b1;
      adv_valid      <= 1'b0;
      adv_len        <= '0;
      anchor_fwd     <= 1'b0;
      restart_valid  <= 1'b0;
      restart_rewind <= 1'b0;
      match_valid    <= 1'b0;
      match_id       <= '0;
    end else begin
      pc             <= pc_next;
      adv_valid      <= step.adv;
      adv_len        <= len;
      anchor_fwd     <= step.adv && fbit;
      restart_valid  <= step.restart;
      restart_rewind <= step.restart && !nofail_q;
      match_valid    <= step.match;
      if (step.match) match_id <= off;
      if (accept || step.match) seen_q <= step.seen_set;
      if (step.restart || step.match) nofail_q <= 1'b1;
      else if (step.adv)              nofail_q <= fbit;
    end
  end
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
  import rxs_pkg::*;
#(
  parameter int PC_W  = 6,
  parameter int CTL_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ctl_word,
  input logic [PC_W-1:0]  pc,
  input logic             cmp_valid,
  input logic             cmp_hit,
  input logic             cmp_ready,
  input logic             adv_valid,
  input logic             anchor_fwd,
  input logic             restart_valid,
  input logic             match_valid
);
  logic [2:0] opc;
  assign opc = ctl_word[CTL_W-1 -: 3];

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && opc != OP_MATCH) |=> $stable(pc));

  a_r5_star_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && opc == OP_STAR && cmp_hit) |=> $stable(pc));

  a_r8_match_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> (pc == '0));

  a_r3_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> (pc == '0));

  a_r10_anchor_with_adv: assert property (@(posedge clk) disable iff (!rst_n)
    anchor_fwd |-> adv_valid);

  a_r11_event_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({adv_valid, restart_valid, match_valid}));

  a_r4_orx_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && opc == OP_ORX && !cmp_hit) |=> (!adv_valid && !restart_valid));
endmodule

bind regex_seq rxs_checker #(.PC_W(PC_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .pc(pc),
  .cmp_valid(cmp_valid), .cmp_hit(cmp_hit), .cmp_ready(cmp_ready),
  .adv_valid(adv_valid), .anchor_fwd(anchor_fwd),
  .restart_valid(restart_valid), .match_valid(match_valid)
);

// File: tb/regex_seq_test.sv
module regex_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ctl_word;
  logic [5:0]  pc;
  logic        cmp_valid, cmp_hit, cmp_ready;
  logic        adv_valid, anchor_fwd, restart_valid, restart_rewind, match_valid;
  logic [1:0]  adv_len;
  logic [7:0]  match_id;

  always #5 clk = ~clk;

  logic [13:0] prog [64];
  assign ctl_word = prog[pc];

  regex_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word), .pc(pc),
    .cmp_valid(cmp_valid), .cmp_hit(cmp_hit), .cmp_ready(cmp_ready),
    .adv_valid(adv_valid), .adv_len(adv_len), .anchor_fwd(anchor_fwd),
    .restart_valid(restart_valid), .restart_rewind(restart_rewind),
    .match_valid(match_valid), .match_id(match_id)
  );

  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [13:0] mk(int op, int f, int ln, int off);
    return {3'(op), 1'(f), 2'(ln), 8'(off)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_pc; bit m_nofail, m_seen;
  bit e_adv, e_anchor, e_rst, e_rw, e_match;
  int e_len, e_id;
  string e_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_nofail = 1; m_seen = 0;
      e_adv = 0; e_anchor = 0; e_rst = 0; e_rw = 0; e_match = 0;
      e_tag = "R1";
    end else begin
      int op, f, ln, off;
      bit consumed, restart, hit;
      op = int'(prog[m_pc][13:11]); f = int'(prog[m_pc][10]);
      ln = int'(prog[m_pc][9:8]);   off = int'($signed(prog[m_pc][7:0]));
      consumed = 0; restart = 0; hit = cmp_hit;
      e_match = 0; e_tag = "R11";
      if (op == 5) begin
        e_match = 1; e_id = int'(prog[m_pc][7:0]); m_pc = 0;
        m_nofail = 1; m_seen = 0; e_tag = "R8";
      end else if (cmp_valid) begin
        case (op)
          1: begin e_tag = "R4"; if (hit) begin consumed = 1; m_pc++; end else m_pc += off; end
          2: begin e_tag = "R5"; if (hit) consumed = 1; else m_pc++; end
          3: begin
            e_tag = "R6";
            if (hit) consumed = 1;
            else if (m_seen) m_pc++;
            else begin restart = 1; m_pc = 0; end
          end
          4: begin e_tag = "R7"; consumed = hit; m_pc++; end
          default: begin e_tag = "R3"; if (hit) begin consumed = 1; m_pc++; end
                   else begin restart = 1; m_pc = 0; end end
        endcase
        m_pc = m_pc & 63;
        m_seen = (op == 3) && hit;
      end
      e_adv = consumed; e_len = ln; e_anchor = consumed && f;
      e_rst = restart; e_rw = restart && !m_nofail;
      if (restart) m_nofail = 1; else if (consumed) m_nofail = f;
    end
  end

  task automatic compare_all();
    chk({e_tag, " pc"}, pc, m_pc);
    chk("R2 cmp_ready", cmp_ready, int'(prog[m_pc][13:11]) != 5);
    chk({e_tag, " adv_valid"}, adv_valid, e_adv);
    if (e_adv) chk("R12 adv_len", adv_len, e_len);
    chk("R10 anchor_fwd", anchor_fwd, e_anchor);
    chk({e_tag, " restart_valid"}, restart_valid, e_rst);
    chk("R9 restart_rewind", restart_rewind, e_rw);
    chk("R8 match_valid", match_valid, e_match);
    if (e_match) chk("R8 match_id", match_id, e_id);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = mk(0, 1, 0, 0);
    prog[0]  = mk(1, 1, 2, 7);      // ORX, miss jumps to 7
    prog[1]  = mk(2, 0, 1, 0);      // STAR F=0
    prog[2]  = mk(3, 1, 1, 0);      // PLUS
    prog[3]  = mk(0, 0, 3, 0);      // CMP F=0
    prog[4]  = mk(4, 0, 0, 0);      // OPT
    prog[5]  = mk(0, 1, 0, 0);      // CMP
    prog[6]  = mk(5, 1, 0, 1);      // MATCH 1
    prog[7]  = mk(0, 1, 3, 0);      // CMP
    prog[8]  = mk(1, 1, 1, -8);     // ORX, miss jumps back to 0
    prog[9]  = mk(6, 0, 2, 0);      // reserved code acts as CMP
    prog[10] = mk(5, 1, 0, 2);      // MATCH 2
    rst_n = 0; cmp_valid = 0; cmp_hit = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", pc, 0);
    chk("R1 adv_valid", adv_valid, 0);
    chk("R1 restart_valid", restart_valid, 0);
    chk("R1 match_valid", match_valid, 0);
    chk("R1 anchor_fwd", anchor_fwd, 0);
    rst_n = 1;
    for (int phase = 0; phase < 4; phase++) begin
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        compare_all();
        cmp_valid = ($urandom_range(0, 99) < (phase == 3 ? 40 : 80));
        cmp_hit   = ($urandom_range(0, 99) < (phase == 0 ? 80 : phase == 1 ? 30 : 60));
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule